// File: doc/BRIEF.md
# Repeated String Move and Load Engine

This block runs string transfers of the kind a CISC processor executes for its block-move and block-load instructions. It holds a source pointer, a destination pointer, a count, an accumulator and a direction flag. It talks to a simple synchronous memory port that accepts one access at a time and acknowledges each access with a one-cycle pulse.

A host loads the architectural registers through a configuration strobe while the engine is idle. It then issues a start pulse that carries the operation fields:
- copy or load;
- narrow or wide element, with an operand-size override that picks the 16-bit width;
- an optional repeat prefix;
- an address-size override, which the engine refuses.

The engine steps element by element until the operation ends. It then raises `done` for one cycle, and `err` alongside it when the request was refused. The resulting register values stay visible on the outputs.

Top module: `strmv_engine`

## Requirements
- R1: After reset the pointers, count and accumulator are zero, the direction flag is clear, and `busy`, `done`, `err` and `mem_req` are low.
- R2: A `cfg_we` pulse while idle loads source, destination, count, accumulator and direction from the `cfg_*` inputs. A `cfg_we` pulse while busy changes none of them.
- R3: The element size is decoded from the start fields as follows. `op_wide`=0 selects a byte (`mem_size`=0), and `op_osz` is ignored in that case. `op_wide`=1 with `op_osz`=1 selects a 16-bit word (`mem_size`=1). `op_wide`=1 with `op_osz`=0 selects a 32-bit doubleword (`mem_size`=2). `mem_size` never takes the value 3.
- R4: In copy mode (`op_copy`=1), each element is a read at the source pointer followed by a write at the destination pointer. The write data equals the low element bytes of the read data, held in little-endian lane order, with all higher bytes zero.
- R5: In load mode (`op_copy`=0), each element is a single read at the source pointer. The read replaces the low element bytes of the accumulator and keeps its upper bytes. No write is made and the destination pointer does not move.
- R6: After each element, every pointer that the mode moves steps by the element size in bytes. It steps up when the direction flag is 0 and down when it is 1, wrapping modulo 2^ADDR_W.
- R7: With the repeat prefix and a count of zero, the operation completes with no memory access and no register change.
- R8: With the repeat prefix and a count of N>0, exactly N elements are transferred. The count drops by one per element and ends at zero.
- R9: Without the repeat prefix, exactly one element is transferred and the count is left unchanged.
- R10: A start with `op_asz`=1 produces `done` together with `err` and makes no memory access and no register change. `err` is never high without `done`.
- R11: Once `mem_req` is raised, it stays high and `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` stay stable until the cycle in which `mem_ack` is seen.
- R12: A start accepted while idle makes `busy` high from the next cycle until `done`. `done` is a single-cycle pulse. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the register file from the cfg inputs (idle only) |
| cfg_src | input | ADDR_W | Source pointer value to load |
| cfg_dst | input | ADDR_W | Destination pointer value to load |
| cfg_cnt | input | CNT_W | Count value to load |
| cfg_acc | input | 32 | Accumulator value to load |
| cfg_dir | input | 1 | Direction flag to load (1 = descending) |
| start | input | 1 | Begin an operation (idle only) |
| op_copy | input | 1 | 1 = copy, 0 = load into accumulator |
| op_wide | input | 1 | 0 = byte element, 1 = word or doubleword |
| op_osz | input | 1 | Operand-size override: word instead of doubleword |
| op_rep | input | 1 | Repeat prefix: iterate on the count |
| op_asz | input | 1 | Address-size override: request is refused |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Refused request, high with done |
| src_ptr | output | ADDR_W | Current source pointer |
| dst_ptr | output | ADDR_W | Current destination pointer |
| count | output | CNT_W | Current count |
| acc | output | 32 | Current accumulator |
| dir_flag | output | 1 | Current direction flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Write data, little-endian lanes |
| mem_size | output | 2 | Access size code 0/1/2 = 1/2/4 bytes |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle access acknowledge |

## Verification
Two situations are hard to reach from the ports. The first is a start or configuration strobe that arrives while a repeated copy is halfway through and the memory is stalling. The second is a descending stride that crosses address zero. The stimulus covers the first case by stretching the acknowledge latency and injecting a conflicting start and register write two cycles into a repeated transfer. It covers the second by placing the pointers just above zero with the direction flag set. Memory returns junk in the bytes above each element, so any failure to mask the write data or to preserve the upper accumulator bytes shows up. One overlapping copy checks that the engine reads back bytes it wrote one element earlier.

// File: rtl/strmv_pkg.sv
package strmv_pkg;

   localparam int DATA_W = 32;
   localparam int LANES  = DATA_W / 8;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_CHK  = 3'd1,
      ST_RD   = 3'd2,
      ST_WR   = 3'd3,
      ST_FIN  = 3'd4
   } st_e;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_W = 2'd1,
      SZ_D = 2'd2
   } sz_e;

   typedef struct packed {
      logic copy;
      logic rep;
      logic bad;
      sz_e  sz;
   } op_t;

   function automatic logic [2:0] sz_bytes(sz_e s);
      case (s)
         SZ_B:    return 3'd1;
         SZ_W:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/strmv_step.sv
module strmv_step
   import strmv_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] ptr_i,
   input  sz_e               sz_i,
   input  logic              dec_i,
   output logic [ADDR_W-1:0] ptr_o
);
   logic [ADDR_W-1:0] delta;

   assign delta = ADDR_W'(sz_bytes(sz_i));
   assign ptr_o = dec_i ? (ptr_i - delta) : (ptr_i + delta);
endmodule

// File: rtl/strmv_lane.sv
module strmv_lane
   import strmv_pkg::*;
(
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [DATA_W-1:0] acc_i,
   input  sz_e               sz_i,
   output logic [DATA_W-1:0] masked_o,
   output logic [DATA_W-1:0] merged_o
);
   logic [2:0]       nbytes;
   logic [LANES-1:0] keep;

   assign nbytes = sz_bytes(sz_i);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign keep[g]              = (3'(g) < nbytes);
      assign masked_o[g*8 +: 8]   = keep[g] ? rdata_i[g*8 +: 8] : 8'h00;
      assign merged_o[g*8 +: 8]   = keep[g] ? rdata_i[g*8 +: 8] : acc_i[g*8 +: 8];
   end
endmodule

// File: rtl/strmv_ctrl.sv
module strmv_ctrl
   import strmv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic op_copy,
   input  logic op_wide,
   input  logic op_osz,
   input  logic op_rep,
   input  logic op_asz,
   input  logic cnt_zero,
   input  logic mem_ack,
   output st_e  st,
   output op_t  op
);
   sz_e sz_dec;

   assign sz_dec = !op_wide ? SZ_B : (op_osz ? SZ_W : SZ_D);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_IDLE;
         op <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               op.copy <= op_copy;
               op.rep  <= op_rep;
               op.bad  <= op_asz;
               op.sz   <= sz_dec;
               st      <= op_asz ? ST_FIN : ST_CHK;
            end
            ST_CHK:  st <= (op.rep && cnt_zero) ? ST_FIN : ST_RD;
            ST_RD:   if (mem_ack) begin
               if (op.copy)     st <= ST_WR;
               else if (op.rep) st <= ST_CHK;
               else             st <= ST_FIN;
            end
            ST_WR:   if (mem_ack) st <= op.rep ? ST_CHK : ST_FIN;
            ST_FIN:  st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/strmv_engine.sv
module strmv_engine
   import strmv_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_src,
   input  logic [ADDR_W-1:0] cfg_dst,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic [31:0]       cfg_acc,
   input  logic              cfg_dir,
   input  logic              start,
   input  logic              op_copy,
   input  logic              op_wide,
   input  logic              op_osz,
   input  logic              op_rep,
   input  logic              op_asz,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] src_ptr,
   output logic [ADDR_W-1:0] dst_ptr,
   output logic [CNT_W-1:0]  count,
   output logic [31:0]       acc,
   output logic              dir_flag,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   output logic [1:0]        mem_size,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack
);
   localparam int NPTR = 2;

   if (ADDR_W < 8 || ADDR_W > 64) begin : g_bad_aw
      $error("strmv_engine: ADDR_W out of range");
   end
   if (CNT_W < 1) begin : g_bad_cw
      $error("strmv_engine: CNT_W must be positive");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("strmv_engine: data path must be 32 bits");
   end

   st_e               st;
   op_t               op;
   logic [ADDR_W-1:0] ptr_cur [NPTR];
   logic [ADDR_W-1:0] ptr_nxt [NPTR];
   logic [31:0]       masked, merged, wbuf;
   logic [CNT_W-1:0]  cnt_dec;

   strmv_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .op_copy(op_copy), .op_wide(op_wide), .op_osz(op_osz),
      .op_rep(op_rep), .op_asz(op_asz),
      .cnt_zero(count == '0), .mem_ack(mem_ack),
      .st(st), .op(op)
   );

   assign ptr_cur[0] = src_ptr;
   assign ptr_cur[1] = dst_ptr;

   for (genvar p = 0; p < NPTR; p++) begin : g_step
      strmv_step #(.ADDR_W(ADDR_W)) u_step (
         .ptr_i(ptr_cur[p]), .sz_i(op.sz), .dec_i(dir_flag), .ptr_o(ptr_nxt[p])
      );
   end

   strmv_lane u_lane (
      .rdata_i(mem_rdata), .acc_i(acc), .sz_i(op.sz),
      .masked_o(masked), .merged_o(merged)
   );

   assign cnt_dec = count - CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_ptr  <= '0;
         dst_ptr  <= '0;
         count    <= '0;
         acc      <= '0;
         dir_flag <= 1'b0;
         wbuf     <= '0;
      end else begin
         if (st == ST_IDLE && cfg_we) begin
            src_ptr  <= cfg_src;
            dst_ptr  <= cfg_dst;
            count    <= cfg_cnt;
            acc      <= cfg_acc;
            dir_flag <= cfg_dir;
         end
         if (st == ST_RD && mem_ack) begin
            if (op.copy) begin
               wbuf <= masked;
            end else begin
               acc     <= merged;
               src_ptr <= ptr_nxt[0];
               if (op.rep) count <= cnt_dec;
            end
         end
         if (st == ST_WR && mem_ack) begin
            src_ptr <= ptr_nxt[0];
            dst_ptr <= ptr_nxt[1];
            if (op.rep) count <= cnt_dec;
         end
      end
   end

   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_FIN);
   assign err       = done && op.bad;
   assign mem_req   = (st == ST_RD) || (st == ST_WR);
   assign mem_we    = (st == ST_WR);
   assign mem_addr  = (st == ST_WR) ? dst_ptr : src_ptr;
   assign mem_size  = op.sz;
   assign mem_wdata = (st == ST_WR) ? wbuf : 32'h0;
endmodule

// File: rtl/strmv_engine_chk.sv
module strmv_engine_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [1:0]        mem_size,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_wdata
);
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_size) && $stable(mem_wdata));

   a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r12_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start |=> busy);

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !done);

   a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_size != 2'd3);

   a_r4_wdata_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_size == 2'd0 |-> mem_wdata[31:8] == 24'h0);

   a_r4_wdata_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_size == 2'd1 |-> mem_wdata[31:16] == 16'h0);
endmodule

bind strmv_engine strmv_engine_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_strmv_engine.sv
module tb_strmv_engine;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_dir, start;
   logic [31:0] cfg_src, cfg_dst, cfg_cnt, cfg_acc;
   logic        op_copy, op_wide, op_osz, op_rep, op_asz;
   logic        busy, done, err, dir_flag;
   logic [31:0] src_ptr, dst_ptr, count, acc;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size;

   always #5 clk = ~clk;

   strmv_engine dut (.*);

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // reference state
   logic [7:0]  mem [int unsigned];
   logic [31:0] e_src, e_dst, e_cnt, e_acc, m_buf;
   bit          e_dir, m_phase, m_copy, m_rep;
   int          m_left, m_n, lat, wcnt;
   logic [1:0]  m_sz;
   bit          hold_v, hold_we;
   logic [31:0] hold_a;

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_tb();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   function automatic logic [7:0] rb(logic [31:0] a);
      if (mem.exists(a)) return mem[a];
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   function automatic logic [31:0] stepp(logic [31:0] p);
      return e_dir ? p - 32'(m_n) : p + 32'(m_n);
   endfunction

   task automatic service();
      logic [31:0] a, rd;
      a = mem_addr;
      rd = {rb(a + 32'd3), rb(a + 32'd2), rb(a + 32'd1), rb(a)};
      mem_rdata = rd;
      if (m_left == 0) begin
         chk(0, "R7 R10 unexpected access", a, 32'h0);
         return;
      end
      chk(mem_we == m_phase, "R4 R5 access kind", 32'(mem_we), 32'(m_phase));
      chk(a == (m_phase ? e_dst : e_src), "R6 access address", a, m_phase ? e_dst : e_src);
      chk(mem_size == m_sz, "R3 access size", 32'(mem_size), 32'(m_sz));
      if (!m_phase) begin
         if (m_copy) begin
            m_buf = 32'h0;
            for (int k = 0; k < m_n; k++) m_buf[8*k +: 8] = rd[8*k +: 8];
            m_phase = 1'b1;
         end else begin
            for (int k = 0; k < m_n; k++) e_acc[8*k +: 8] = rd[8*k +: 8];
            e_src = stepp(e_src);
            if (m_rep) e_cnt = e_cnt - 1;
            m_left--;
         end
      end else begin
         chk(mem_wdata == m_buf, "R4 write data", mem_wdata, m_buf);
         for (int k = 0; k < m_n; k++) mem[a + 32'(k)] = m_buf[8*k +: 8];
         e_src = stepp(e_src);
         e_dst = stepp(e_dst);
         if (m_rep) e_cnt = e_cnt - 1;
         m_left--;
         m_phase = 1'b0;
      end
   endtask

   // memory model and per-clock protocol compare
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_v) begin
            chk(mem_req == 1'b1, "R11 request dropped", 32'(mem_req), 32'h1);
            if (mem_req) begin
               chk(mem_addr == hold_a && mem_we == hold_we, "R11 request changed",
                   mem_addr, hold_a);
            end
         end
         if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt    = 0;
            hold_v  = 1'b0;
         end else if (mem_req) begin
            if (wcnt >= lat) begin
               service();
               mem_ack = 1'b1;
               wcnt    = 0;
               hold_v  = 1'b0;
            end else begin
               wcnt++;
               hold_v  = 1'b1;
               hold_a  = mem_addr;
               hold_we = mem_we;
            end
         end else begin
            hold_v = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(0, "R12 watchdog expired", 32'(cyc), 32'd150000);
         finish_tb();
      end
   end

   task automatic check_regs(string tag);
      chk(src_ptr == e_src, {tag, " R6 source pointer"}, src_ptr, e_src);
      chk(dst_ptr == e_dst, {tag, " R6 destination pointer"}, dst_ptr, e_dst);
      chk(count == e_cnt, {tag, " R8 R9 count"}, count, e_cnt);
      chk(acc == e_acc, {tag, " R5 accumulator"}, acc, e_acc);
      chk(dir_flag == e_dir, {tag, " R2 direction"}, 32'(dir_flag), 32'(e_dir));
   endtask

   task automatic set_regs(logic [31:0] s, logic [31:0] d, logic [31:0] c,
                           logic [31:0] a, bit dr);
      cfg_src = s; cfg_dst = d; cfg_cnt = c; cfg_acc = a; cfg_dir = dr;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      e_src = s; e_dst = d; e_cnt = c; e_acc = a; e_dir = dr;
      check_regs("R2 load");
   endtask

   task automatic run_op(bit cp, bit wd, bit os, bit rp, bit az, int l, bit poke);
      int n;
      lat     = l;
      m_copy  = cp;
      m_rep   = rp;
      m_sz    = !wd ? 2'd0 : (os ? 2'd1 : 2'd2);
      m_n     = 1 << m_sz;
      m_phase = 1'b0;
      m_left  = az ? 0 : (rp ? int'(e_cnt) : 1);
      op_copy = cp; op_wide = wd; op_osz = os; op_rep = rp; op_asz = az;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      chk(busy == 1'b1, "R12 busy after start", 32'(busy), 32'h1);
      n = 0;
      while (!done && n < 4000) begin
         if (poke && n == 2) begin
            start = 1'b1; op_copy = ~cp; op_rep = 1'b0; op_asz = 1'b1;
            cfg_we = 1'b1; cfg_src = 32'hDEAD_0000; cfg_dst = 32'hBEEF_0000;
            cfg_cnt = 32'h99; cfg_acc = 32'h1234_5678; cfg_dir = ~e_dir;
         end else begin
            start = 1'b0; cfg_we = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0; cfg_we = 1'b0;
      if (n >= 4000) chk(0, "R12 no done", 32'(n), 32'd4000);
      chk(err == az, "R10 err flag", 32'(err), 32'(az));
      chk(m_left == 0, "R8 R9 element count", 32'(m_left), 32'h0);
      check_regs("op end");
      @(negedge clk);
      chk(!done && !busy, "R12 done single pulse", {30'h0, done, busy}, 32'h0);
   endtask

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; start = 1'b0; mem_ack = 1'b0; mem_rdata = 32'h0;
      cfg_src = 0; cfg_dst = 0; cfg_cnt = 0; cfg_acc = 0; cfg_dir = 0;
      op_copy = 0; op_wide = 0; op_osz = 0; op_rep = 0; op_asz = 0;
      lat = 0; wcnt = 0; hold_v = 0; m_left = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(src_ptr == 0 && dst_ptr == 0 && count == 0 && acc == 0 && !dir_flag,
          "R1 reset registers", src_ptr | dst_ptr | count | acc, 32'h0);
      chk(!busy && !done && !err && !mem_req, "R1 reset controls",
          {28'h0, busy, done, err, mem_req}, 32'h0);

      // R4 R9: single byte copy, count untouched
      set_regs(32'h0000_1000, 32'h0000_2000, 32'd7, 32'hAABB_CCDD, 1'b0);
      run_op(1, 0, 0, 0, 0, 0, 0);
      // R8: repeated doubleword copy ascending
      set_regs(32'h0000_1100, 32'h0000_2100, 32'd4, 32'h0, 1'b0);
      run_op(1, 1, 0, 1, 0, 1, 0);
      // R6 R12 R2: repeated word copy descending with a conflicting start/cfg mid-way
      set_regs(32'h0000_1200, 32'h0000_2200, 32'd3, 32'h0, 1'b1);
      run_op(1, 1, 1, 1, 0, 2, 1);
      // R5: byte load keeps accumulator upper bytes
      set_regs(32'h0000_1300, 32'h0000_2300, 32'd5, 32'h1122_3344, 1'b0);
      run_op(0, 0, 0, 0, 0, 1, 0);
      // R5 R8: repeated word load descending
      set_regs(32'h0000_1400, 32'h0000_2400, 32'd3, 32'hCAFE_F00D, 1'b1);
      run_op(0, 1, 1, 1, 0, 0, 1);
      // R5: repeated doubleword load ascending
      set_regs(32'h0000_1500, 32'h0000_2500, 32'd2, 32'h0, 1'b0);
      run_op(0, 1, 0, 1, 0, 3, 0);
      // R7: repeat with zero count
      set_regs(32'h0000_1600, 32'h0000_2600, 32'd0, 32'h5555_AAAA, 1'b0);
      run_op(1, 1, 0, 1, 0, 0, 0);
      // R10: address-size override refused
      set_regs(32'h0000_1700, 32'h0000_2700, 32'd3, 32'h7777_0000, 1'b0);
      run_op(1, 1, 0, 1, 1, 0, 0);
      // R3: operand-size override ignored for byte elements
      set_regs(32'h0000_1800, 32'h0000_2800, 32'd2, 32'h0, 1'b0);
      run_op(1, 0, 1, 1, 0, 0, 0);
      // R6: descending stride wraps below zero
      set_regs(32'h0000_0001, 32'h0000_0002, 32'd2, 32'h0, 1'b1);
      run_op(1, 1, 0, 1, 0, 1, 0);
      // R4: overlapping ascending byte copy reads back earlier writes
      set_regs(32'h0000_3000, 32'h0000_3001, 32'd6, 32'h0, 1'b0);
      run_op(1, 0, 0, 1, 0, 0, 0);
      chk(mem[32'h0000_3006] == rb(32'h0000_3000), "R4 overlap propagation",
          32'(mem[32'h0000_3006]), 32'(rb(32'h0000_3000)));
      finish_tb();
   end
endmodule